// File: doc/BRIEF.md
# Twenty-Four-Hour Timekeeper with Minute Alarm

This block keeps the time of day as six BCD digits (hours, minutes, seconds) and drives them from a fast system clock. A tick generator divides the system clock down to one enable pulse per counted second. A rate input picks the divide ratio: a full one-second period for normal use, or a short period so that a day can be run through quickly in test. The digits form a ripple-enable chain. Each digit steps only on the cycle in which every digit below it rolls over. The hour pair is limited to 23, and the tick after 23:59:59 returns every digit to zero.

An alarm register holds an hour and a minute in BCD. It is loaded from plain input pins whenever a load strobe is high at a clock edge. The alarm output is a pure compare of the running hour and minute digits against the stored values. It is therefore high for the whole minute that matches and low in every other minute. An active-low asynchronous reset clears the time, the stored alarm and the divider. All pins are plain control and status pins, so there is no handshake at the edge of the block.

Top module: `daytime_clock_alarm`

## Requirements
- R1: While rst_ni is low, digits_o reads 00:00:00 and the tick divider restarts. The reset takes effect without waiting for a clock edge. The stored alarm becomes 00:00.
- R2: With rate_sec_i high, the time advances once every SLOW_CYC clock cycles. The first advance after reset release comes on the SLOW_CYC-th rising edge.
- R3: With rate_sec_i low, the time advances once every FAST_CYC clock cycles.
- R4: Each advance moves the time forward by exactly one second, and no other edge changes the time.
- R5: The seconds units digit counts 0 to 9. The seconds tens digit counts 0 to 5 and steps only when the units digit wraps from 9 to 0.
- R6: The minutes digits behave like the seconds digits and step only when the seconds wrap from 59 to 00.
- R7: The hours run from 00 to 23. The advance after 23:59:59 gives 00:00:00.
- R8: When alm_load_i is high at a rising edge, alm_hh_i and alm_mm_i are stored as the alarm time. In each of these, bits [7:4] hold the tens digit and bits [3:0] the units digit.
- R9: alarm_o is high exactly while the hour and minute digits equal the stored alarm, whatever the seconds digits hold.
- R10: digits_o holds, from bit 23 down, these six nibbles: hours tens, hours units, minutes tens, minutes units, seconds tens, seconds units.
- R11: If the divider count already meets or exceeds the new period when rate_sec_i changes, the next edge produces an advance and the count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sec_i | input | 1 | 1 selects the one-second period, 0 the fast test period |
| alm_load_i | input | 1 | Stores the alarm time at the rising edge |
| alm_hh_i | input | 8 | Alarm hour, two BCD digits |
| alm_mm_i | input | 8 | Alarm minute, two BCD digits |
| digits_o | output | 24 | Current time, six BCD digits |
| alarm_o | output | 1 | High while hour and minute match the alarm |

## Verification
A divider count that is wrong shows up as a time advance that comes early or late on digits_o. That error can be seen within one tick period of the fault. A broken carry or limit in the digit chain shows up on the edge where a digit should wrap. It gives an out-of-range nibble or a skipped step, and the time no longer matches a simple seconds-of-day count. An alarm register that holds the wrong value, or a compare that is wrong, shows as alarm_o disagreeing with the minute digits. At the latest this is seen at the next minute boundary or the next load.

// File: rtl/clk24_pkg.sv
package clk24_pkg;
  localparam int NDIG = 6;
  localparam int DW   = 4;

  // Highest value each digit reaches before wrapping, index 0 = seconds units.
  function automatic logic [DW-1:0] digit_max(input int idx);
    case (idx)
      1, 3:    digit_max = 4'd5;
      5:       digit_max = 4'd2;
      default: digit_max = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int SLOW_CYC = 50_000_000,
  parameter int FAST_CYC = 250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rate_sec_i,
  output logic tick_o
);
  localparam int MAXC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CYC - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last   = rate_sec_i ? SLOW_LAST : FAST_LAST;
  assign tick_o = (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit #(
  parameter logic [3:0] MAX = 4'd9
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       clr_i,
  output logic [3:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  val_o <= '0;
    else if (clr_i)               val_o <= '0;
    else if (step_i) begin
      if (val_o == MAX)           val_o <= '0;
      else                        val_o <= val_o + 4'd1;
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [7:0]  hh_i,
  input  logic [7:0]  mm_i,
  input  logic [15:0] now_hhmm_i,
  output logic        match_o
);
  logic [15:0] set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     set_q <= '0;
    else if (load_i) set_q <= {hh_i, mm_i};
  end

  assign match_o = (now_hhmm_i == set_q);
endmodule

// File: rtl/daytime_clock_alarm.sv
module daytime_clock_alarm
  import clk24_pkg::*;
#(
  parameter int SLOW_CYC = 50_000_000,
  parameter int FAST_CYC = 250_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rate_sec_i,
  input  logic        alm_load_i,
  input  logic [7:0]  alm_hh_i,
  input  logic [7:0]  alm_mm_i,
  output logic [23:0] digits_o,
  output logic        alarm_o
);
  logic            tick;
  logic [NDIG-1:0] step;
  logic [DW-1:0]   dig [NDIG];
  logic            day_end;

  tick_divider #(.SLOW_CYC(SLOW_CYC), .FAST_CYC(FAST_CYC)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_sec_i (rate_sec_i),
    .tick_o     (tick)
  );

  assign step[0] = tick;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    bcd_digit #(.MAX(digit_max(i))) u_d (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (step[i]),
      .clr_i  (day_end),
      .val_o  (dig[i])
    );
    if (i < NDIG - 1) begin : g_chain
      assign step[i+1] = step[i] && (dig[i] == digit_max(i));
    end
    assign digits_o[DW*i +: DW] = dig[i];
  end

  // Carry into the hour units while hours read 23 ends the day.
  assign day_end = step[4] && (dig[5] == 4'd2) && (dig[4] == 4'd3);

  alarm_match u_alm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (alm_load_i),
    .hh_i       (alm_hh_i),
    .mm_i       (alm_mm_i),
    .now_hhmm_i (digits_o[23:8]),
    .match_o    (alarm_o)
  );
endmodule

// File: rtl/clk24_checker.sv
module clk24_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        alm_load_i,
  input logic [23:0] digits_o,
  input logic        alarm_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_clear: assert (digits_o == 24'h0)
        else $error("R1 digits not clear in reset");
    end
  end

  a_r5_sec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o[3:0] <= 4'd9) && (digits_o[7:4] <= 4'd5));

  a_r6_min_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o[11:8] <= 4'd9) && (digits_o[15:12] <= 4'd5));

  a_r7_hour_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o[23:16] <= 8'h23) && (digits_o[19:16] <= 4'd9));

  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digits_o[3:0] != $past(digits_o[3:0])) |->
      ((digits_o[3:0] == $past(digits_o[3:0]) + 4'd1) ||
       ($past(digits_o[3:0]) == 4'd9 && digits_o[3:0] == 4'd0)));

  a_r9_alarm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o != $past(alarm_o)) |->
      ((digits_o[23:8] != $past(digits_o[23:8])) || $past(alm_load_i)));
endmodule

bind daytime_clock_alarm clk24_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alm_load_i (alm_load_i),
  .digits_o   (digits_o),
  .alarm_o    (alarm_o)
);

// File: tb/daytime_clock_alarm_tb_top.sv
module daytime_clock_alarm_tb_top;
  localparam int SLOW = 7;
  localparam int FAST = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate = 1'b1;
  logic        load = 1'b0;
  logic [7:0]  a_hh = 8'h00;
  logic [7:0]  a_mm = 8'h00;
  logic [23:0] digits;
  logic        alarm;

  int ld_h = 0;
  int ld_m = 0;
  int m_cnt = 0;
  int m_secs = 0;
  int m_alm = 0;
  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;
  string t_req = "R1";
  string a_req = "R9";

  always #5 clk = ~clk;

  daytime_clock_alarm #(.SLOW_CYC(SLOW), .FAST_CYC(FAST)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rate_sec_i (rate),
    .alm_load_i (load),
    .alm_hh_i   (a_hh),
    .alm_mm_i   (a_mm),
    .digits_o   (digits),
    .alarm_o    (alarm)
  );

  // Behavioural reference: seconds of day, divider count, alarm minute of day.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= 0;
      m_secs <= 0;
      m_alm  <= 0;
    end else begin
      if (m_cnt >= (rate ? SLOW : FAST) - 1) begin
        m_cnt  <= 0;
        m_secs <= (m_secs + 1) % 86400;
      end else begin
        m_cnt <= m_cnt + 1;
      end
      if (load) m_alm <= ld_h * 60 + ld_m;
    end
  end

  function automatic logic [23:0] pack(input int s);
    int h, m, x;
    h = s / 3600; m = (s / 60) % 60; x = s % 60;
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(x / 10), 4'(x % 10)};
  endfunction

  task automatic compare();
    logic [23:0] exp_d;
    logic        exp_a;
    exp_d = pack(m_secs);
    exp_a = ((m_secs / 60) == m_alm);
    n_vec++;
    if (digits !== exp_d) begin
      n_bad++;
      $display("FAIL %s digits=%h expected=%h", t_req, digits, exp_d);
    end
    n_vec++;
    if (alarm !== exp_a) begin
      n_bad++;
      $display("FAIL %s alarm=%b expected=%b at %h", a_req, alarm, exp_a, exp_d);
    end
  endtask

  always @(negedge clk) if (!finished) compare();

  task automatic set_alarm(input int h, input int m);
    ld_h = h; ld_m = m;
    a_hh = {4'(h / 10), 4'(h % 10)};
    a_mm = {4'(m / 10), 4'(m % 10)};
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 199000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state, R10 layout checked by every compare
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 R4 R10: one-second rate
    t_req = "R2 R4 R10";
    repeat (40) @(negedge clk);
    // R11: switch while count is beyond the fast period
    while (m_cnt < 3) @(negedge clk);
    t_req = "R11 R3";
    rate = 1'b0;
    repeat (6) @(negedge clk);
    // R8 R9: alarm at 00:03, visible over that whole minute
    t_req = "R3 R5 R6";
    a_req = "R8 R9";
    set_alarm(0, 3);
    while (m_secs < 3700) @(negedge clk);
    set_alarm(1, 2);
    t_req = "R5 R6 R7";
    while (m_secs < 86300) @(negedge clk);
    set_alarm(23, 59);
    t_req = "R7";
    while (m_secs != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    // R1: asynchronous reset mid-run, seen before any edge
    #2 rst_n = 1'b0;
    #1;
    n_vec++;
    if (digits !== 24'h0 || alarm !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 digits=%h alarm=%b expected=000000 1", digits, alarm);
    end
    t_req = "R1";
    a_req = "R1 R9";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rate = 1'b1;
    t_req = "R2";
    repeat (30) @(negedge clk);
    finish_run();
  end
endmodule